// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block takes packed stereo sample words from the processor side and sends them out as a two-channel serial audio stream. Each 32-bit word holds one left and one right 16-bit sample. The block keeps one word in a holding buffer. At every frame boundary that word moves into a 32-bit shift register, which then sends left and right samples MSB first in I2S framing. The bit clock and the word-select line are generated inside the block from the system clock.

Writes use a valid/ready handshake. `s_ready` is the transmit-ready flag, and it is high whenever the holding buffer is empty. A word is taken on any clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, the producer must hold off, and whatever it drives is ignored. Software can poll `s_ready`, or it can wait for the `irq` pulse that marks the buffer being emptied into the shifter. If no word is waiting when a frame starts, the block sends silence and raises a sticky `underrun` flag. The next accepted word clears that flag.

Top module: `stereo_i2s_tx`

## Requirements
- R1: An accepted word is sent with bits 15:0 (left) in the slot where `ws` is low and bits 31:16 (right) in the slot where `ws` is high. Each slot is 16 bits long and sent MSB first.
- R2: `sd` and `ws` change only on falling edges of `sck`. They are stable at every rising edge. `ws` changes one bit clock before the MSB of the slot it announces (I2S one-bit delay).
- R3: `sck` has a period of 2*HALF_DIV system clocks, and a frame is 32 `sck` periods long.
- R4: `s_ready` is high exactly when the holding buffer is empty. A word is accepted when `s_valid` and `s_ready` are both high at a clock edge. After that, `s_ready` stays low, and the buffered word stays unchanged, until the next frame boundary.
- R5: At a frame boundary where the buffer is full, the word moves to the shifter. `s_ready` rises and `irq` pulses high for exactly one clock, both in that same cycle.
- R6: At a frame boundary where the buffer is empty, the whole next frame is sent as zeros and `underrun` is set.
- R7: `underrun` stays set until the next accepted write clears it.
- R8: After reset, `sck`=0, `ws`=1, `sd`=0, `s_ready`=1, `irq`=0 and `underrun`=0.
- R9: While `s_ready` is low, `s_valid` and `s_data` have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Producer offers a stereo word |
| s_ready | output | 1 | Transmit-ready: holding buffer is empty |
| s_data | input | 32 | Stereo word, right in 31:16, left in 15:0 |
| irq | output | 1 | One-clock pulse when the buffer is emptied into the shifter |
| underrun | output | 1 | Sticky flag: a frame began with no word waiting |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: 0 for the left slot, 1 for the right slot |
| sd | output | 1 | Serial data, changing on the falling edge of `sck` |

## Verification
The bench decodes the serial stream as a receiver would. A fault in the shift register or in the slot counter therefore shows up as a wrong frame, decoded at the frame boundary that follows it, which is at most two frame periods after the word was written. A wrong buffer-full state shows up at once, in `s_ready` on the next clock, or as a missing or doubled `irq` pulse and a false `underrun` at the next frame boundary. Bit-clock and slot-length faults show up within one slot as a wrong `sck` period or a wrong count of bits between `ws` edges.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  localparam int SLOT_W     = 16;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);

  // Bus word layout: right channel in the upper half, left in the lower half.
  typedef struct packed {
    logic [SLOT_W-1:0] right;
    logic [SLOT_W-1:0] left;
  } stereo_word_t;
endpackage

// File: rtl/i2stx_clkgen.sv
module i2stx_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck,
  output logic tick_fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_q;
  logic          sck_q;
  logic          wrap;

  assign wrap      = (div_q == CW'(HALF_DIV - 1));
  assign tick_fall = wrap && sck_q;
  assign sck       = sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: a falling tick is always followed by sck low
  p_fall_lowers_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |=> !sck);
endmodule

// File: rtl/i2stx_holdbuf.sv
module i2stx_holdbuf
  import i2stx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [31:0]  wr_data,
  input  logic         take,
  output stereo_word_t word,
  output logic         word_ok,
  output logic         irq,
  output logic         err
);
  logic         full_q;
  stereo_word_t data_q;
  logic         irq_q;
  logic         err_q;
  logic         acc;

  assign wr_ready = !full_q;
  assign acc      = wr_valid && !full_q;
  assign word     = data_q;
  assign word_ok  = full_q;
  assign irq      = irq_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q <= take && full_q;
      if (acc) begin
        full_q <= 1'b1;
        data_q <= stereo_word_t'(wr_data);
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (take && !full_q) err_q <= 1'b1;
      else if (acc)        err_q <= 1'b0;
    end
  end

  // R4: a full buffer keeps its word and stays not-ready until taken
  p_hold_until_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !take) |=> (!wr_ready && $stable(word)));
  // R5: a take with no write in the same cycle frees the buffer
  p_ready_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc) |=> wr_ready);
  // R5: the request is a single-cycle pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7: an accepted write clears the sticky error
  p_err_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !take) |=> !err);
endmodule

// File: rtl/i2stx_shifter.sv
module i2stx_shifter
  import i2stx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  stereo_word_t word,
  input  logic         word_ok,
  output logic         frame_edge,
  output logic         ws,
  output logic         sd
);
  logic [POS_W-1:0]      pos_q;
  logic [POS_W-1:0]      pos_nx;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  ws_q;
  logic                  sd_q;

  assign frame_edge = tick && (pos_q == POS_W'(FRAME_BITS - 1));
  assign pos_nx     = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
  assign ws         = ws_q;
  assign sd         = sd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= POS_W'(FRAME_BITS - 1);
      sh_q  <= '0;
      ws_q  <= 1'b1;
      sd_q  <= 1'b0;
    end else if (tick) begin
      pos_q <= pos_nx;
      sd_q  <= sh_q[FRAME_BITS-1];
      ws_q  <= (pos_nx >= POS_W'(SLOT_W));
      if (frame_edge)
        sh_q <= word_ok ? {word.left, word.right} : '0;
      else
        sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  // R6: an empty buffer at the boundary loads silence
  p_underrun_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && !word_ok) |=> (sh_q == '0));
endmodule

// File: rtl/stereo_i2s_tx.sv
module stereo_i2s_tx
  import i2stx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  output logic        irq,
  output logic        underrun,
  output logic        sck,
  output logic        ws,
  output logic        sd
);
  logic         tick_fall;
  logic         frame_edge;
  stereo_word_t buf_word;
  logic         buf_ok;

  i2stx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .tick_fall (tick_fall)
  );

  i2stx_holdbuf u_holdbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (s_valid),
    .wr_ready (s_ready),
    .wr_data  (s_data),
    .take     (frame_edge),
    .word     (buf_word),
    .word_ok  (buf_ok),
    .irq      (irq),
    .err      (underrun)
  );

  i2stx_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_fall),
    .word       (buf_word),
    .word_ok    (buf_ok),
    .frame_edge (frame_edge),
    .ws         (ws),
    .sd         (sd)
  );

  // R2: serial lines are steady when the receiver samples on the rising edge
  p_stable_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(sd) && $stable(ws)));
endmodule

// File: tb/stereo_i2s_tx_tb.sv
module stereo_i2s_tx_tb;
  localparam int HALF_DIV = 2;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h8000_7FFF, 32'hFFFF_0000, 32'h0001_8000,
    32'hA5A5_5A5A, 32'h1234_ABCD, 32'h0000_FFFF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, irq, underrun, sck, ws, sd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stereo_i2s_tx #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .irq(irq), .underrun(underrun),
    .sck(sck), .ws(ws), .sd(sd)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // receiver model
  logic [31:0] frames [0:15];
  int nfr = 0;
  logic [31:0] rx = '0;
  logic ws_prev = 1'b1;
  int run_len = 0;
  int slot_len [0:1] = '{0, 0};
  int last_rise = -1;
  int sck_period = 0;

  always @(posedge sck) begin
    rx = {rx[30:0], sd};
    if (ws_prev && !ws && nfr < 16) begin
      frames[nfr] = rx;
      nfr = nfr + 1;
    end
    if (ws != ws_prev) begin
      slot_len[ws_prev] = run_len;
      run_len = 1;
    end else begin
      run_len = run_len + 1;
    end
    ws_prev = ws;
    if (last_rise >= 0) sck_period = cyc - last_rise;
    last_rise = cyc;
  end

  int irq_count = 0;
  logic irq_last = 1'b0;
  int irq_wide = 0;
  always @(negedge clk) begin
    if (irq) irq_count = irq_count + 1;
    if (irq && irq_last) irq_wide = irq_wide + 1;
    irq_last = irq;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] on_wire(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction

  task automatic wait_frames(input int n);
    while (nfr < n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finish_run();
    end
  end

  initial begin
    bit saw_irq;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 sck", {31'b0, sck}, 32'd0);
    check("R8 ws", {31'b0, ws}, 32'd1);
    check("R8 sd", {31'b0, sd}, 32'd0);
    check("R8 ready/irq/underrun", {29'b0, s_ready, irq, underrun}, 32'b100);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      saw_irq = 1'b0;
      if (!s_ready) begin
        while (!s_ready) @(negedge clk);
        saw_irq = irq;
        // R5: irq accompanies the ready rise
        check("R5 irq with ready", {31'b0, saw_irq}, 32'd1);
      end
      s_valid = 1'b1;
      s_data  = VEC[i];
      @(negedge clk);
      s_valid = 1'b0;
      // R4: buffer now full
      check("R4 ready low after write", {31'b0, s_ready}, 32'd0);
      if (i == 2) begin
        // R9: junk offered while not ready
        s_valid = 1'b1;
        s_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        s_valid = 1'b0;
        check("R9 junk not accepted", {31'b0, s_ready}, 32'd0);
      end
    end

    wait_frames(NV + 1);
    repeat (2) @(negedge clk);
    // R1 / R9: decoded frames match table
    for (int i = 0; i < NV; i++)
      check("R1 frame", frames[i+1], on_wire(VEC[i]));
    // R6: running dry raises the flag
    check("R6 underrun set", {31'b0, underrun}, 32'd1);
    // R5: one irq per word loaded, each one cycle wide
    check("R5 irq count", irq_count, NV);
    check("R5 irq width", irq_wide, 0);
    // R2: slot lengths between ws edges
    check("R2 left slot bits", slot_len[0], 16);
    check("R2 right slot bits", slot_len[1], 16);
    // R3: bit clock period
    check("R3 sck period", sck_period, 2 * HALF_DIV);

    wait_frames(NV + 2);
    repeat (2) @(negedge clk);
    check("R6 silent frame", frames[NV+1], 32'h0);
    // R7: still set after another frame
    check("R7 sticky", {31'b0, underrun}, 32'd1);
    s_valid = 1'b1;
    s_data  = 32'h4321_8765;
    @(negedge clk);
    s_valid = 1'b0;
    check("R7 cleared by write", {31'b0, underrun}, 32'd0);
    wait_frames(NV + 4);
    repeat (2) @(negedge clk);
    check("R1 after recovery", frames[NV+3], on_wire(32'h4321_8765));
    finish_run();
  end
endmodule